// File: doc/BRIEF.md
# FP/Vector Register Access Permission Checker

This block decides whether an instruction that touches the floating-point or vector register file may run. It takes the current privilege level, the register width (64-bit or 32-bit) of each level, the security state and the implemented extensions, and the relevant control bits from the OS, hypervisor and monitor levels. It returns one verdict: no fault, an undefined-instruction fault, or a trap to a higher level. A trap or fault comes with its target level, exception class and syndrome.

Two rule sets exist. The 64-bit rule set applies when the current level runs in 64-bit state. It checks the OS enable field first, then the hypervisor trap bit, then the monitor trap bit. The 32-bit rule set applies otherwise. In that set, non-secure access-control bits can override the OS and hypervisor controls, and the set hands over to the 64-bit rules in specific cases. The checks run in a fixed order, and the first one that fails decides the result. A request strobe starts an evaluation. One cycle later the registered verdict appears together with a valid pulse.

Top module: `fpsimd_perm_chk`

## Requirements
- R1: A request on `req_i` produces `valid_o` high in the next cycle, and every cycle without a request is followed by `valid_o` low. The result fields change only on requests.
- R2: After reset, `valid_o`, `err_o`, `fault_o`, `tgt_lvl_o`, `ec_o` and `iss_o` are all zero. Fault encoding: 0 = none, 1 = undefined instruction, 2 = trap.
- R3: A `cur_lvl_i` value above 3 sets `err_o` and reports fault 0 with target, class and syndrome all zero.
- R4: The 64-bit rule set applies when the bit of `lvl_is64_i` indexed by the current level is set. At level 0 with `os_fpen_i` not 2'b11, or at level 1 with `os_fpen_i[0]` clear, the result is a trap to level 1 with class 0x07 and syndrome 0x1E00000.
- R5: When the R4 check passes, the 64-bit trap checks follow in this order. With virtualization present, level 2 or below, and `hyp_tfp_i` set, the result is a trap to level 2. Otherwise, with security present and `mon_tfp_i` set, the result is a trap to level 3. Both traps use class 0x07 and syndrome 0x1E00000.
- R6: In the 32-bit rule set, an access at level 0 when level 1 is 64-bit gets the R4/R5 result.
- R7: With security present, level 3 32-bit and non-secure state: a set `ns_vec_dis_i` forces the vector disable on, and a clear `ns_cp10_i` forces the cp10 field to zero.
- R8: In the 32-bit rule set, when not at level 2, the result is undefined instruction in any of these cases: a vector access with the effective vector disable set, level 0 with the effective cp10 not 2'b11, or level 1 or 3 with effective cp10 bit 0 clear. The target is level 1 from level 0 and otherwise the current level, with class 0 and syndrome 0.
- R9: When `fpx_chk_i` is set and `fpx_en_i` is clear, the 32-bit rule set reports undefined instruction with the R8 target, class and syndrome.
- R10: In the 32-bit rule set, with virtualization present, non-secure state and level 2 64-bit, the result is the R5 check alone.
- R11: Otherwise, with virtualization present and non-secure state, the hypervisor check applies. The trap condition is a vector access with the vector-trap bit set, or the cp10 trap bit set. Under the R7 condition, `ns_vec_dis_i` forces the vector-trap bit on and `ns_cp10_i` forces the cp10 trap bit on. The check reports class 0x08, with syndrome 0x20 for a vector access and 0xA otherwise. The fault is undefined instruction at level 2 and a trap to level 2 at any other level.
- R12: As the last 32-bit check, with security present, level 3 64-bit and `mon_tfp_i` set, the result is a trap to level 3 with class 0x07 and syndrome 0x1E00000.
- R13: When no check fails, the result is fault 0 with class and syndrome zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Evaluate the current inputs |
| cur_lvl_i | input | 3 | Current privilege level; values above 3 are invalid |
| lvl_is64_i | input | 4 | Bit n set: level n runs in 64-bit state |
| nonsec_i | input | 1 | Non-secure state |
| has_virt_i | input | 1 | Virtualization extension present |
| has_sec_i | input | 1 | Security extension present |
| os_fpen_i | input | 2 | OS-level FP enable field (64-bit rule set) |
| os_cp10_i | input | 2 | OS-level cp10 enable field (32-bit rule set) |
| os_vec_dis_i | input | 1 | OS-level vector disable |
| hyp_tfp_i | input | 1 | Hypervisor FP trap bit (64-bit form) |
| mon_tfp_i | input | 1 | Monitor FP trap bit |
| hyp_cp10_trap_i | input | 1 | Hypervisor cp10 trap bit (32-bit form) |
| hyp_vec_trap_i | input | 1 | Hypervisor vector trap bit (32-bit form) |
| ns_vec_dis_i | input | 1 | Non-secure vector disable override |
| ns_cp10_i | input | 1 | Non-secure cp10 access bit |
| fpx_en_i | input | 1 | FP-exception unit enable |
| fpx_chk_i | input | 1 | The enable in `fpx_en_i` must be checked |
| vec_op_i | input | 1 | The access is a vector operation |
| valid_o | output | 1 | Result valid |
| err_o | output | 1 | Invalid level on the request |
| fault_o | output | 2 | 0 none, 1 undefined instruction, 2 trap |
| tgt_lvl_o | output | 2 | Target level of the fault |
| ec_o | output | 6 | Exception class |
| iss_o | output | 25 | Syndrome value |

## Verification
The assertions assume that `req_i` and all evaluation inputs are known and stable around each rising edge. They also assume that a level above 3 is reported only through `err_o` and never as a fault. The bench changes inputs only at falling edges and holds them for a full cycle. It draws about 40,000 requests from a shift-register generator. The draws favour enable fields at 2'b11 and clear trap bits, so that evaluations reach the late checks in the chain. About one in eight requests carries an invalid level.

// File: rtl/fpsimd_perm_pkg.sv
package fpsimd_perm_pkg;
  localparam int EC_W  = 6;
  localparam int ISS_W = 25;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_UNDEF = 2'd1,
    FLT_TRAP  = 2'd2
  } flt_e;

  localparam logic [EC_W-1:0]  EC_FP_ACC   = 6'h07;
  localparam logic [EC_W-1:0]  EC_CP_CTRL  = 6'h08;
  localparam logic [ISS_W-1:0] ISS_FP_ACC  = 25'h1E00000;
  localparam logic [ISS_W-1:0] ISS_CP_VEC  = 25'h20;
  localparam logic [ISS_W-1:0] ISS_CP_REG  = 25'h0A;

  typedef struct packed {
    flt_e              kind;
    logic [LVL_W-1:0]  tgt;
    logic [EC_W-1:0]   ec;
    logic [ISS_W-1:0]  iss;
  } perm_res_t;

  localparam perm_res_t RES_OK = '{kind: FLT_NONE, tgt: '0, ec: '0, iss: '0};

  function automatic perm_res_t mk_res(flt_e k, logic [LVL_W-1:0] t,
                                       logic [EC_W-1:0] e, logic [ISS_W-1:0] s);
    perm_res_t r;
    r.kind = k;
    r.tgt  = t;
    r.ec   = e;
    r.iss  = s;
    return r;
  endfunction
endpackage

// File: rtl/fpsimd_perm_a64.sv
module fpsimd_perm_a64
  import fpsimd_perm_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             has_virt_i,
  input  logic             has_sec_i,
  input  logic [1:0]       fpen_i,
  input  logic             hyp_tfp_i,
  input  logic             mon_tfp_i,
  output perm_res_t        en_res_o,
  output perm_res_t        trp_res_o
);
  logic os_block;

  // hypervisor then monitor trap bits
  always_comb begin
    trp_res_o = RES_OK;
    if (has_virt_i && (cur_lvl_i <= LVL_W'(2)) && hyp_tfp_i)
      trp_res_o = mk_res(FLT_TRAP, LVL_W'(2), EC_FP_ACC, ISS_FP_ACC);
    else if (has_sec_i && mon_tfp_i)
      trp_res_o = mk_res(FLT_TRAP, LVL_W'(3), EC_FP_ACC, ISS_FP_ACC);
  end

  assign os_block = ((cur_lvl_i == LVL_W'(0)) && (fpen_i != 2'b11)) ||
                    ((cur_lvl_i == LVL_W'(1)) && !fpen_i[0]);

  assign en_res_o = os_block ? mk_res(FLT_TRAP, LVL_W'(1), EC_FP_ACC, ISS_FP_ACC)
                             : trp_res_o;
endmodule

// File: rtl/fpsimd_perm_a32.sv
module fpsimd_perm_a32
  import fpsimd_perm_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic [NLVL-1:0]  lvl_is64_i,
  input  logic             nonsec_i,
  input  logic             has_virt_i,
  input  logic             has_sec_i,
  input  logic [1:0]       cp10_i,
  input  logic             vec_dis_i,
  input  logic             hyp_cp10_trap_i,
  input  logic             hyp_vec_trap_i,
  input  logic             ns_vec_dis_i,
  input  logic             ns_cp10_i,
  input  logic             mon_tfp_i,
  input  logic             fpx_en_i,
  input  logic             fpx_chk_i,
  input  logic             vec_op_i,
  input  perm_res_t        en64_i,
  input  perm_res_t        trp64_i,
  output perm_res_t        res_o
);
  logic             ns_ovr, eff_vdis, eff_htase, eff_hcp10, os_undef, hyp_hit;
  logic [1:0]       eff_cp10;
  logic [LVL_W-1:0] und_tgt;
  logic [ISS_W-1:0] hyp_iss;

  assign ns_ovr    = has_sec_i && !lvl_is64_i[NLVL-1] && nonsec_i;
  assign eff_vdis  = vec_dis_i | (ns_ovr & ns_vec_dis_i);
  assign eff_cp10  = (ns_ovr && !ns_cp10_i) ? 2'b00 : cp10_i;
  assign eff_htase = hyp_vec_trap_i | (ns_ovr & ns_vec_dis_i);
  assign eff_hcp10 = hyp_cp10_trap_i | (ns_ovr & ns_cp10_i);

  assign os_undef = (cur_lvl_i != LVL_W'(2)) &&
                    ((vec_op_i && eff_vdis) ||
                     ((cur_lvl_i == LVL_W'(0)) && (eff_cp10 != 2'b11)) ||
                     ((cur_lvl_i != LVL_W'(0)) && !eff_cp10[0]));
  assign hyp_hit  = (vec_op_i && eff_htase) || eff_hcp10;
  assign und_tgt  = (cur_lvl_i == LVL_W'(0)) ? LVL_W'(1) : cur_lvl_i;
  assign hyp_iss  = vec_op_i ? ISS_CP_VEC : ISS_CP_REG;

  always_comb begin
    res_o = RES_OK;
    if ((cur_lvl_i == LVL_W'(0)) && lvl_is64_i[1])
      res_o = en64_i;
    else if (os_undef || (fpx_chk_i && !fpx_en_i))
      res_o = mk_res(FLT_UNDEF, und_tgt, '0, '0);
    else if (has_virt_i && nonsec_i && lvl_is64_i[2])
      res_o = trp64_i;
    else if (has_virt_i && nonsec_i && hyp_hit)
      res_o = mk_res((cur_lvl_i == LVL_W'(2)) ? FLT_UNDEF : FLT_TRAP,
                     LVL_W'(2), EC_CP_CTRL, hyp_iss);
    else if (has_sec_i && lvl_is64_i[NLVL-1] && mon_tfp_i)
      res_o = mk_res(FLT_TRAP, LVL_W'(3), EC_FP_ACC, ISS_FP_ACC);
  end
endmodule

// File: rtl/fpsimd_perm_chk.sv
module fpsimd_perm_chk
  import fpsimd_perm_pkg::*;
#(
  parameter int LVL_IN_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [LVL_IN_W-1:0] cur_lvl_i,
  input  logic [3:0]          lvl_is64_i,
  input  logic                nonsec_i,
  input  logic                has_virt_i,
  input  logic                has_sec_i,
  input  logic [1:0]          os_fpen_i,
  input  logic [1:0]          os_cp10_i,
  input  logic                os_vec_dis_i,
  input  logic                hyp_tfp_i,
  input  logic                mon_tfp_i,
  input  logic                hyp_cp10_trap_i,
  input  logic                hyp_vec_trap_i,
  input  logic                ns_vec_dis_i,
  input  logic                ns_cp10_i,
  input  logic                fpx_en_i,
  input  logic                fpx_chk_i,
  input  logic                vec_op_i,
  output logic                valid_o,
  output logic                err_o,
  output logic [1:0]          fault_o,
  output logic [1:0]          tgt_lvl_o,
  output logic [5:0]          ec_o,
  output logic [24:0]         iss_o
);
  logic             lvl_bad;
  logic [LVL_W-1:0] lvl;
  perm_res_t        en64, trp64, res32, res_d, res_q;
  logic             valid_q, err_q;

  assign lvl_bad = cur_lvl_i > LVL_IN_W'(NLVL - 1);
  assign lvl     = cur_lvl_i[LVL_W-1:0];

  fpsimd_perm_a64 u_a64 (
    .cur_lvl_i  (lvl),
    .has_virt_i (has_virt_i),
    .has_sec_i  (has_sec_i),
    .fpen_i     (os_fpen_i),
    .hyp_tfp_i  (hyp_tfp_i),
    .mon_tfp_i  (mon_tfp_i),
    .en_res_o   (en64),
    .trp_res_o  (trp64)
  );

  fpsimd_perm_a32 u_a32 (
    .cur_lvl_i       (lvl),
    .lvl_is64_i      (lvl_is64_i),
    .nonsec_i        (nonsec_i),
    .has_virt_i      (has_virt_i),
    .has_sec_i       (has_sec_i),
    .cp10_i          (os_cp10_i),
    .vec_dis_i       (os_vec_dis_i),
    .hyp_cp10_trap_i (hyp_cp10_trap_i),
    .hyp_vec_trap_i  (hyp_vec_trap_i),
    .ns_vec_dis_i    (ns_vec_dis_i),
    .ns_cp10_i       (ns_cp10_i),
    .mon_tfp_i       (mon_tfp_i),
    .fpx_en_i        (fpx_en_i),
    .fpx_chk_i       (fpx_chk_i),
    .vec_op_i        (vec_op_i),
    .en64_i          (en64),
    .trp64_i         (trp64),
    .res_o           (res32)
  );

  assign res_d = lvl_bad ? RES_OK : (lvl_is64_i[lvl] ? en64 : res32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        err_q <= lvl_bad;
        res_q <= res_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign fault_o   = res_q.kind;
  assign tgt_lvl_o = res_q.tgt;
  assign ec_o      = res_q.ec;
  assign iss_o     = res_q.iss;

  a_r1_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r1_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r3_err_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (fault_o == FLT_NONE));
  a_r13_clean_when_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == FLT_NONE) |-> (ec_o == '0 && iss_o == '0));
  a_r5_fp_class_syndrome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ec_o == EC_FP_ACC) |-> (iss_o == ISS_FP_ACC && fault_o == FLT_TRAP));
  a_r11_hyp_undef_at_l2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == FLT_UNDEF && ec_o == EC_CP_CTRL) |-> (tgt_lvl_o == 2'd2));
  a_r4_trap_never_l0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == FLT_TRAP) |-> (tgt_lvl_o != 2'd0));
endmodule

// File: tb/fpsimd_perm_chk_tb.sv
`timescale 1ns/1ps
module fpsimd_perm_chk_tb_top;
  localparam int NVEC = 40000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] cl = '0;
  logic [3:0] is64 = '0;
  logic ns = 0, hv = 0, hs = 0, vdis = 0, htfp = 0, mtfp = 0, hcp = 0, hvec = 0;
  logic nsv = 0, nsc = 0, fen = 0, fchk = 0, vec = 0;
  logic [1:0] fpen = '0, cp10 = '0;
  logic valid, err;
  logic [1:0] fault, tgt;
  logic [5:0] ec;
  logic [24:0] iss;

  logic [1:0] ek, et;
  logic [5:0] ee;
  logic [24:0] es;
  logic eerr;
  string etag;
  int errors = 0, checks = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #2 clk = ~clk;

  fpsimd_perm_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cur_lvl_i(cl), .lvl_is64_i(is64),
    .nonsec_i(ns), .has_virt_i(hv), .has_sec_i(hs), .os_fpen_i(fpen), .os_cp10_i(cp10),
    .os_vec_dis_i(vdis), .hyp_tfp_i(htfp), .mon_tfp_i(mtfp), .hyp_cp10_trap_i(hcp),
    .hyp_vec_trap_i(hvec), .ns_vec_dis_i(nsv), .ns_cp10_i(nsc), .fpx_en_i(fen),
    .fpx_chk_i(fchk), .vec_op_i(vec), .valid_o(valid), .err_o(err), .fault_o(fault),
    .tgt_lvl_o(tgt), .ec_o(ec), .iss_o(iss)
  );

  task automatic put(input logic [1:0] k, input logic [1:0] t, input logic [5:0] e,
                     input logic [24:0] s, input string tag);
    ek = k; et = t; ee = e; es = s; etag = tag;
  endtask

  // 64-bit trap bits in priority order (R5)
  task automatic trap_bits(input logic [1:0] l, input string tag);
    if (hv && l <= 2 && htfp) put(2, 2, 6'h07, 25'h1E00000, tag);
    else if (hs && mtfp) put(2, 3, 6'h07, 25'h1E00000, tag);
  endtask

  task automatic predict;
    logic [1:0] l, c10;
    logic ovr, vd, tase, tcp;
    put(0, 0, 0, 0, "R13");
    eerr = 1'b0;
    if (cl > 3) begin eerr = 1'b1; etag = "R3"; return; end
    l = cl[1:0];
    if (is64[l] || (l == 0 && is64[1])) begin   // R4 / R6
      if ((l == 0 && fpen != 2'b11) || (l == 1 && !fpen[0])) put(2, 1, 6'h07, 25'h1E00000, "R4");
      else trap_bits(l, "R5");
      return;
    end
    ovr  = hs && !is64[3] && ns;                    // R7
    vd   = vdis || (ovr && nsv);
    c10  = (ovr && !nsc) ? 2'b00 : cp10;
    tase = hvec || (ovr && nsv);
    tcp  = hcp || (ovr && nsc);
    if (l != 2 && ((vec && vd) || (l == 0 ? (c10 != 3) : !c10[0]))) begin
      put(1, (l == 0) ? 2'd1 : l, 0, 0, "R8"); return;
    end
    if (fchk && !fen) begin put(1, (l == 0) ? 2'd1 : l, 0, 0, "R9"); return; end
    if (hv && ns && is64[2]) begin trap_bits(l, "R10"); return; end
    if (hv && ns && ((vec && tase) || tcp)) begin
      put((l == 2) ? 2'd1 : 2'd2, 2, 6'h08, vec ? 25'h20 : 25'h0A, "R11"); return;
    end
    if (hs && is64[3] && mtfp) put(2, 3, 6'h07, 25'h1E00000, "R12");
  endtask

  task automatic chk(input string tag, input logic [37:0] act, input logic [37:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (lvl=%0d is64=%b)", tag, act, exp_v, cl, is64);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2", {valid, err, fault, tgt, ec, iss, 1'b0}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", {valid, err, fault, tgt, ec, iss, 1'b0}, '0);
    for (int n = 0; n < NVEC; n++) begin
      rs = nxt(rs); r = rs;
      rs = nxt(rs); r2 = rs;
      cl   = (r[4:2] == 3'd0) ? {1'b1, r[1:0]} : {1'b0, r[1:0]};
      is64 = r[8:5];
      ns   = r[9];  hv = r[10]; hs = r[11];
      fpen = (r[12] | r[13]) ? 2'b11 : r[15:14];
      cp10 = (r[16] | r[17]) ? 2'b11 : r[19:18];
      vdis = r[20] & r[21];
      htfp = r[22] & r[23];
      mtfp = r[24] & r[25];
      hcp  = r2[0] & r2[1];
      hvec = r2[2] & r2[3];
      nsv  = r2[4] & r2[5];
      nsc  = r2[6] | r2[7];
      fen  = r2[8] | r2[9];
      fchk = r2[10];
      vec  = r2[11];
      req  = 1'b1;
      predict();
      @(negedge clk);
      // R1: valid one cycle after request; result fields per rule tag
      chk("R1", {1'b0, valid, 36'd0}, {1'b0, 1'b1, 36'd0});
      chk(etag, {err, fault, tgt, ec, iss, 2'b0}, {eerr, ek, et, ee, es, 2'b0});
      if (n % 1000 == 999) begin
        req = 1'b0;
        cl = 3'd0; is64 = 4'h0; fpen = 2'b00; cp10 = 2'b00;
        @(negedge clk);
        // R1: idle cycle drops valid and holds the previous result
        chk("R1", {1'b0, valid, err, fault, tgt, ec, iss, 1'b0},
                  {1'b0, 1'b0, eerr, ek, et, ee, es, 1'b0});
      end
    end
    req = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule